// File: doc/BRIEF.md
# Logarithmic Block Motion Search Engine

The engine finds an integer motion vector for one 16x16 luma block of the current picture. It searches a 48x48 pixel window taken from the previous picture, with the block's own position at window coordinate (16,16). A caller first writes the current block and the window one byte at a time through a small write port. It then pulses `start`. The engine runs a four-stage logarithmic search. Each stage scores a 3x3 grid of candidate displacements by their sum of absolute differences (SAD). The grid spacing is 8, 4, 2 and then 1 pixel, and each grid is centred on the winner of the stage before it.

A seed input moves the first centre, for example to a predicted vector. A skip control drops the coarse 8-pixel stage when the seed is already close. The datapath reads two block rows per cycle, which keeps every search inside a fixed cycle budget. The block returns the winning displacement, its SAD and a one-cycle done pulse.

Top module: `lsme_top`

## Requirements
- R1: With `ld_win`=0, a write with `ld_en`=1 stores `ld_data` at current-block pixel (row `ld_row[3:0]`, column `ld_col[3:0]`). With `ld_win`=1 it stores the byte at window pixel (row `ld_row`, column `ld_col`), both in 0..47. Window pixel (16+dy+r, 16+dx+c) is the reference for block pixel (r,c) at displacement (dx,dy). Writes are only made while `busy` is low.
- R2: The SAD of a displacement is the unsigned 16-bit sum over all 256 block pixels of |current - reference|.
- R3: The search has stages with steps 8, 4, 2 and 1. Each stage scores centre + (i*step, j*step) for i,j in {-1,0,1}. The next stage is centred on the stage winner. The result is the winner of the step-1 stage.
- R4: Each coordinate of every candidate is clamped to -16..+16, so `mv_x` and `mv_y` always lie in -16..+16.
- R5: Candidates are scored in raster order (top row first, left to right), and a later candidate wins only with a strictly smaller SAD. In every stage after the first, the centre (the previous winner) is not rescored. It keeps its SAD and ranks ahead of all eight neighbours on a tie.
- R6: The first centre is (`seed_x`,`seed_y`), each coordinate clamped to -16..+16 and read as signed two's complement. With `skip_coarse`=1 the search starts at step 4 and scores all nine points of that first stage.
- R7: `busy` rises in the cycle after `start` is taken and falls in the cycle in which `done` is high for exactly one cycle. That cycle comes at most 512 cycles after `start` was sampled.
- R8: `start` is ignored while `busy` is high. `mv_x`, `mv_y` and `best_sad` change only when `done` pulses and hold their values otherwise.
- R9: After reset, `busy` and `done` are 0 and `mv_x`, `mv_y` and `best_sad` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Byte write strobe |
| ld_win | input | 1 | 1 selects the search window, 0 the current block |
| ld_row | input | 6 | Row of the written byte |
| ld_col | input | 6 | Column of the written byte |
| ld_data | input | 8 | Pixel value |
| start | input | 1 | Start pulse, taken only when idle |
| skip_coarse | input | 1 | Begin at step 4 instead of step 8 |
| seed_x | input | 6 | Signed initial horizontal centre |
| seed_y | input | 6 | Signed initial vertical centre |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result pulse |
| mv_x | output | 6 | Signed horizontal displacement of the winner |
| mv_y | output | 6 | Signed vertical displacement of the winner |
| best_sad | output | 16 | SAD of the winner |

## Verification
The hardest behaviour to reach is the tie rule, because ordinary picture content almost never produces equal SADs. Constant pictures make every candidate score the same. A search on them must end on the repeated top-left choice of the first full stage, which after the clamp is a known corner. The clamp and seed paths are reached by copying the current block from the window at an extreme or off-centre displacement. That placement makes the exact answer a centre point that the seeded first stage scores directly. Pseudo-random and smooth-gradient pictures are compared with a stage-by-stage reference that the bench builds from the rules.

// File: rtl/lsme_pkg.sv
package lsme_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } lsme_state_e;

  // Limit a displacement to the symmetric range -lim..+lim.
  function automatic int clamp_disp(input int v, input int lim);
    if (v > lim)  return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

endpackage

// File: rtl/lsme_frame_store.sv
module lsme_frame_store #(
  parameter int MB    = 16,
  parameter int WIN   = 48,
  parameter int PW    = 8,
  parameter int LANES = 2,
  parameter int MVW   = 6,
  localparam int RANGE = (WIN - MB) / 2,
  localparam int RW    = $clog2(WIN),
  localparam int CW    = $clog2(MB),
  localparam int LB    = $clog2(LANES),
  localparam int PAIRW = $clog2(MB / LANES),
  localparam int WDEP  = WIN / LANES,
  localparam int WAW   = $clog2(WDEP)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           ld_en,
  input  logic                           ld_win,
  input  logic [RW-1:0]                  ld_row,
  input  logic [RW-1:0]                  ld_col,
  input  logic [PW-1:0]                  ld_data,
  input  logic                           rd_en,
  input  logic                           rd_first,
  input  logic                           rd_last,
  input  logic [PAIRW-1:0]               rd_pair,
  input  logic signed [MVW-1:0]          cand_x,
  input  logic signed [MVW-1:0]          cand_y,
  output logic                           q_vld,
  output logic                           q_first,
  output logic                           q_last,
  output logic [LANES-1:0][MB*PW-1:0]    q_cur,
  output logic [LANES-1:0][MB*PW-1:0]    q_ref
);

  logic [RW-1:0] rbase;   // window row of lane 0 for this beat
  logic [RW-1:0] col_d;
  logic [RW-1:0] col_q;
  logic [LB-1:0] par_q;
  logic [LANES-1:0][WIN*PW-1:0] wrow_all;

  assign rbase = RW'(RANGE + int'(cand_y) + LANES * int'(rd_pair));
  assign col_d = RW'(RANGE + int'(cand_x));

  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld   <= 1'b0;
      q_first <= 1'b0;
      q_last  <= 1'b0;
      col_q   <= '0;
      par_q   <= '0;
    end else begin
      q_vld   <= rd_en;
      q_first <= rd_en & rd_first;
      q_last  <= rd_en & rd_last;
      if (rd_en) begin
        col_q <= col_d;
        par_q <= rbase[LB-1:0];
      end
    end
  end

  // Window banks: bank b holds the rows whose index is b modulo LANES.
  for (genvar b = 0; b < LANES; b++) begin : g_wbank
    logic [WIN*PW-1:0] wmem [WDEP];
    logic [WIN*PW-1:0] wrow_q;
    logic [LB-1:0]     lane_off;
    logic [RW-1:0]     row_b;
    logic [WAW-1:0]    ridx;
    logic [WAW-1:0]    widx;

    assign lane_off = LB'(b) - rbase[LB-1:0];
    assign row_b    = rbase + RW'(lane_off);
    assign ridx     = WAW'(row_b >> LB);
    assign widx     = WAW'(ld_row >> LB);

    always_ff @(posedge clk) begin
      if (ld_en && ld_win && (ld_row[LB-1:0] == LB'(b)))
        wmem[widx][ld_col*PW +: PW] <= ld_data;
      if (rd_en)
        wrow_q <= wmem[ridx];
    end

    assign wrow_all[b] = wrow_q;
  end

  // Current-block banks: lane l holds rows l, l+LANES, ...
  for (genvar l = 0; l < LANES; l++) begin : g_cbank
    logic [MB*PW-1:0] cmem [MB/LANES];
    logic [MB*PW-1:0] crow_q;
    logic [LB-1:0]    sel;

    always_ff @(posedge clk) begin
      if (ld_en && !ld_win && (ld_row[LB-1:0] == LB'(l)))
        cmem[ld_row[CW-1:LB]][ld_col[CW-1:0]*PW +: PW] <= ld_data;
      if (rd_en)
        crow_q <= cmem[rd_pair];
    end

    assign sel      = par_q + LB'(l);
    assign q_cur[l] = crow_q;
    assign q_ref[l] = wrow_all[sel][col_q*PW +: MB*PW];
  end

  // The window row read for a lane must stay inside the stored window.
  AST_ROW_IN_WIN: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (int'(rbase) + LANES - 1 < WIN));  // R1

endmodule

// File: rtl/lsme_sad_unit.sv
module lsme_sad_unit #(
  parameter int MB    = 16,
  parameter int PW    = 8,
  parameter int LANES = 2,
  parameter int SADW  = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_vld,
  input  logic                        in_first,
  input  logic                        in_last,
  input  logic [LANES-1:0][MB*PW-1:0] in_cur,
  input  logic [LANES-1:0][MB*PW-1:0] in_ref,
  output logic                        out_vld,
  output logic [SADW-1:0]             out_sad
);

  logic [SADW-1:0] beat;
  logic [PW-1:0]   pa;
  logic [PW-1:0]   pb;

  always_comb begin
    beat = '0;
    pa   = '0;
    pb   = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int k = 0; k < MB; k++) begin
        pa   = in_cur[l][k*PW +: PW];
        pb   = in_ref[l][k*PW +: PW];
        beat = beat + SADW'((pa > pb) ? (pa - pb) : (pb - pa));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_sad <= '0;
    end else begin
      out_vld <= in_vld & in_last;
      if (in_vld)
        out_sad <= in_first ? beat : (out_sad + beat);
    end
  end

  AST_ACC_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !in_first) |-> ({1'b0, out_sad} + {1'b0, beat} < (SADW+1)'(1 << SADW)));  // R2

endmodule

// File: rtl/lsme_search_ctrl.sv
module lsme_search_ctrl
  import lsme_pkg::*;
#(
  parameter int MB     = 16,
  parameter int LANES  = 2,
  parameter int MVW    = 6,
  parameter int RANGE  = 16,
  parameter int SADW   = 16,
  parameter int STEP0  = 8,
  parameter int BUDGET = 512,
  localparam int PAIRW = $clog2(MB / LANES),
  localparam int NPAIR = MB / LANES,
  localparam int STW   = $clog2(STEP0) + 1,
  localparam int CYW   = $clog2(BUDGET) + 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic                  skip_coarse,
  input  logic signed [MVW-1:0] seed_x,
  input  logic signed [MVW-1:0] seed_y,
  input  logic                  sad_vld,
  input  logic [SADW-1:0]       sad_in,
  output logic                  rd_en,
  output logic                  rd_first,
  output logic                  rd_last,
  output logic [PAIRW-1:0]      rd_pair,
  output logic signed [MVW-1:0] cand_x,
  output logic signed [MVW-1:0] cand_y,
  output logic                  busy,
  output logic                  done,
  output logic signed [MVW-1:0] mv_x,
  output logic signed [MVW-1:0] mv_y,
  output logic [SADW-1:0]       best_sad
);

  lsme_state_e          state;
  logic [STW-1:0]        step;
  logic signed [MVW-1:0] cen_x, cen_y;
  logic signed [MVW-1:0] bx, by;
  logic [SADW-1:0]       bsad;
  logic [3:0]            idx;
  logic                  full;     // stage scores all nine points
  logic [CYW-1:0]        cyc;

  logic                  take;
  logic [SADW-1:0]       nb_sad;
  logic signed [MVW-1:0] nb_x, nb_y;
  logic [3:0]            nidx;
  int                    dxk, dyk;

  always_comb begin
    dxk    = (int'(idx) % 3) - 1;
    dyk    = (int'(idx) / 3) - 1;
    cand_x = MVW'(clamp_disp(int'(cen_x) + dxk * int'(step), RANGE));
    cand_y = MVW'(clamp_disp(int'(cen_y) + dyk * int'(step), RANGE));
    take   = sad_in < bsad;
    nb_sad = take ? sad_in : bsad;
    nb_x   = take ? cand_x : bx;
    nb_y   = take ? cand_y : by;
    nidx   = (!full && idx == 4'd3) ? 4'd5 : idx + 4'd1;
  end

  assign busy     = (state != S_IDLE);
  assign rd_en    = (state == S_ISSUE);
  assign rd_first = (rd_pair == '0);
  assign rd_last  = (rd_pair == PAIRW'(NPAIR - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      step     <= '0;
      cen_x    <= '0;
      cen_y    <= '0;
      bx       <= '0;
      by       <= '0;
      bsad     <= '0;
      idx      <= '0;
      full     <= 1'b0;
      rd_pair  <= '0;
      cyc      <= '0;
      done     <= 1'b0;
      mv_x     <= '0;
      mv_y     <= '0;
      best_sad <= '0;
    end else begin
      done <= 1'b0;
      if (busy) cyc <= cyc + 1'b1;
      case (state)
        S_IDLE: if (start) begin
          cen_x   <= MVW'(clamp_disp(int'(seed_x), RANGE));
          cen_y   <= MVW'(clamp_disp(int'(seed_y), RANGE));
          step    <= skip_coarse ? STW'(STEP0 / 2) : STW'(STEP0);
          idx     <= '0;
          full    <= 1'b1;
          bsad    <= '1;
          rd_pair <= '0;
          cyc     <= '0;
          state   <= S_ISSUE;
        end
        S_ISSUE: begin
          rd_pair <= rd_pair + 1'b1;
          if (rd_last) state <= S_WAIT;
        end
        default: if (sad_vld) begin
          bsad <= nb_sad;
          bx   <= nb_x;
          by   <= nb_y;
          if (idx == 4'd8) begin
            if (step == STW'(1)) begin
              done     <= 1'b1;
              mv_x     <= nb_x;
              mv_y     <= nb_y;
              best_sad <= nb_sad;
              state    <= S_IDLE;
            end else begin
              step  <= step >> 1;
              cen_x <= nb_x;
              cen_y <= nb_y;
              idx   <= '0;
              full  <= 1'b0;
              state <= S_ISSUE;
            end
          end else begin
            idx   <= nidx;
            state <= S_ISSUE;
          end
        end
      endcase
    end
  end

  AST_BUDGET: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cyc < CYW'(BUDGET)));  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R7
  AST_CAND_RANGE: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (int'(cand_x) <= RANGE && int'(cand_x) >= -RANGE &&
               int'(cand_y) <= RANGE && int'(cand_y) >= -RANGE));  // R4
  AST_BEST_NONINC: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && sad_vld) |=> (bsad <= $past(bsad)));  // R5
  AST_CENTRE_REUSED: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !full) |-> (idx != 4'd4));  // R5
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == S_ISSUE && start) |=> (state != S_IDLE));  // R8

endmodule

// File: rtl/lsme_top.sv
module lsme_top #(
  parameter int MB     = 16,
  parameter int WIN    = 48,
  parameter int PW     = 8,
  parameter int LANES  = 2,
  parameter int MVW    = 6,
  parameter int SADW   = 16,
  parameter int STEP0  = 8,
  parameter int BUDGET = 512,
  localparam int RANGE = (WIN - MB) / 2,
  localparam int RW    = $clog2(WIN),
  localparam int PAIRW = $clog2(MB / LANES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld_en,
  input  logic                  ld_win,
  input  logic [RW-1:0]         ld_row,
  input  logic [RW-1:0]         ld_col,
  input  logic [PW-1:0]         ld_data,
  input  logic                  start,
  input  logic                  skip_coarse,
  input  logic signed [MVW-1:0] seed_x,
  input  logic signed [MVW-1:0] seed_y,
  output logic                  busy,
  output logic                  done,
  output logic signed [MVW-1:0] mv_x,
  output logic signed [MVW-1:0] mv_y,
  output logic [SADW-1:0]       best_sad
);

  logic                        rd_en, rd_first, rd_last;
  logic [PAIRW-1:0]            rd_pair;
  logic signed [MVW-1:0]       cand_x, cand_y;
  logic                        q_vld, q_first, q_last;
  logic [LANES-1:0][MB*PW-1:0] q_cur, q_ref;
  logic                        sad_vld;
  logic [SADW-1:0]             sad_val;

  lsme_frame_store #(
    .MB(MB), .WIN(WIN), .PW(PW), .LANES(LANES), .MVW(MVW)
  ) u_store (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_win(ld_win), .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data),
    .rd_en(rd_en), .rd_first(rd_first), .rd_last(rd_last), .rd_pair(rd_pair),
    .cand_x(cand_x), .cand_y(cand_y),
    .q_vld(q_vld), .q_first(q_first), .q_last(q_last), .q_cur(q_cur), .q_ref(q_ref)
  );

  lsme_sad_unit #(
    .MB(MB), .PW(PW), .LANES(LANES), .SADW(SADW)
  ) u_sad (
    .clk(clk), .rst(rst),
    .in_vld(q_vld), .in_first(q_first), .in_last(q_last),
    .in_cur(q_cur), .in_ref(q_ref),
    .out_vld(sad_vld), .out_sad(sad_val)
  );

  lsme_search_ctrl #(
    .MB(MB), .LANES(LANES), .MVW(MVW), .RANGE(RANGE), .SADW(SADW),
    .STEP0(STEP0), .BUDGET(BUDGET)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .start(start), .skip_coarse(skip_coarse), .seed_x(seed_x), .seed_y(seed_y),
    .sad_vld(sad_vld), .sad_in(sad_val),
    .rd_en(rd_en), .rd_first(rd_first), .rd_last(rd_last), .rd_pair(rd_pair),
    .cand_x(cand_x), .cand_y(cand_y),
    .busy(busy), .done(done), .mv_x(mv_x), .mv_y(mv_y), .best_sad(best_sad)
  );

  AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (rst)
    ld_en |-> !busy);  // R1
  AST_MV_RANGE: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(mv_x) <= RANGE && int'(mv_x) >= -RANGE &&
              int'(mv_y) <= RANGE && int'(mv_y) >= -RANGE));  // R4
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(mv_x) && $stable(mv_y) && $stable(best_sad)));  // R8

endmodule

// File: tb/lsme_top_bench.sv
`timescale 1ns/1ps
module lsme_top_bench;

  localparam int MB = 16;
  localparam int WIN = 48;
  localparam int RNG = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0, ld_win = 1'b0;
  logic [5:0] ld_row = '0, ld_col = '0;
  logic [7:0] ld_data = '0;
  logic start = 1'b0, skip_coarse = 1'b0;
  logic signed [5:0] seed_x = '0, seed_y = '0;
  logic busy, done;
  logic signed [5:0] mv_x, mv_y;
  logic [15:0] best_sad;

  int checks = 0;
  int errors = 0;

  logic [7:0] wbuf [WIN][WIN];
  logic [7:0] cbuf [MB][MB];
  int unsigned lcg = 32'h1234_5678;

  always #4 clk = ~clk;

  lsme_top u_lsme_top (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_win(ld_win), .ld_row(ld_row),
    .ld_col(ld_col), .ld_data(ld_data), .start(start), .skip_coarse(skip_coarse),
    .seed_x(seed_x), .seed_y(seed_y), .busy(busy), .done(done),
    .mv_x(mv_x), .mv_y(mv_y), .best_sad(best_sad)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] rnd8();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[23:16];
  endfunction

  function automatic int clampi(input int v);
    return (v > RNG) ? RNG : ((v < -RNG) ? -RNG : v);
  endfunction

  function automatic int ref_sad(input int dx, input int dy);
    int s = 0;
    for (int r = 0; r < MB; r++)
      for (int c = 0; c < MB; c++) begin
        int a = int'(cbuf[r][c]);
        int b = int'(wbuf[RNG+dy+r][RNG+dx+c]);
        s += (a > b) ? a - b : b - a;
      end
    return s;
  endfunction

  // Stage-by-stage reference built from R3, R4, R5, R6.
  task automatic ref_search(input int sx, input int sy, input bit skip,
                            output int rx, output int ry, output int rs);
    int cx = clampi(sx), cy = clampi(sy);
    int step = skip ? 4 : 8;
    bit full = 1'b1;
    int bx = cx, by = cy, bs = 1 << 30;
    while (step >= 1) begin
      for (int i = 0; i < 9; i++) begin
        int px, py, s;
        if (!full && i == 4) continue;
        px = clampi(cx + (i % 3 - 1) * step);
        py = clampi(cy + (i / 3 - 1) * step);
        s = ref_sad(px, py);
        if (s < bs) begin bs = s; bx = px; by = py; end
      end
      cx = bx; cy = by; step = step / 2; full = 1'b0;
    end
    rx = bx; ry = by; rs = bs;
  endtask

  task automatic load_all();
    for (int r = 0; r < WIN; r++)
      for (int c = 0; c < WIN; c++) begin
        @(negedge clk);
        ld_en = 1'b1; ld_win = 1'b1; ld_row = 6'(r); ld_col = 6'(c); ld_data = wbuf[r][c];
      end
    for (int r = 0; r < MB; r++)
      for (int c = 0; c < MB; c++) begin
        @(negedge clk);
        ld_en = 1'b1; ld_win = 1'b0; ld_row = 6'(r); ld_col = 6'(c); ld_data = cbuf[r][c];
      end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // Copy the current block out of the window at displacement (dx,dy).
  task automatic cur_from_win(input int dx, input int dy);
    for (int r = 0; r < MB; r++)
      for (int c = 0; c < MB; c++)
        cbuf[r][c] = wbuf[RNG+dy+r][RNG+dx+c];
  endtask

  // Runs one search; poke>0 pulses start again that many cycles in.
  task automatic run(input int sx, input int sy, input bit skip, input int poke,
                     output int gx, output int gy, output int gs, output int cyc);
    bit busy_bad = 1'b0;
    @(negedge clk);
    start = 1'b1; seed_x = 6'(sx); seed_y = 6'(sy); skip_coarse = skip;
    @(negedge clk);
    start = 1'b0; seed_x = 6'(-9); seed_y = 6'(9); skip_coarse = ~skip;
    cyc = 1;
    while (!done && cyc < 2000) begin
      if (!busy) busy_bad = 1'b1;
      if (poke > 0 && cyc == poke) start = 1'b1;
      else start = 1'b0;
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    check("R7", "busy while searching", int'(busy_bad), 0);
    check("R7", "busy low with done", int'(busy), 0);
    check("R7", "cycles start to done within 512", int'(cyc <= 512), 1);
    gx = int'(mv_x); gy = int'(mv_y); gs = int'(best_sad);
  endtask

  task automatic compare_ref(input string req, input int sx, input int sy, input bit skip);
    int gx, gy, gs, cyc, rx, ry, rs;
    ref_search(sx, sy, skip, rx, ry, rs);
    run(sx, sy, skip, 0, gx, gy, gs, cyc);
    check(req, "mv_x vs reference", gx, rx);
    check(req, "mv_y vs reference", gy, ry);
    check(req, "best_sad vs reference", gs, rs);
  endtask

  task automatic t_reset();
    check("R9", "busy after reset", int'(busy), 0);
    check("R9", "done after reset", int'(done), 0);
    check("R9", "mv_x after reset", int'(mv_x), 0);
    check("R9", "mv_y after reset", int'(mv_y), 0);
    check("R9", "best_sad after reset", int'(best_sad), 0);
  endtask

  task automatic t_tie_uniform();
    int gx, gy, gs, cyc;
    for (int r = 0; r < WIN; r++) for (int c = 0; c < WIN; c++) wbuf[r][c] = 8'd37;
    for (int r = 0; r < MB; r++) for (int c = 0; c < MB; c++) cbuf[r][c] = 8'd37;
    load_all();
    run(0, 0, 1'b0, 0, gx, gy, gs, cyc);
    check("R5", "all-tie mv_x keeps top-left", gx, -8);
    check("R5", "all-tie mv_y keeps top-left", gy, -8);
    check("R2", "all-tie sad", gs, 0);
    run(15, 15, 1'b0, 0, gx, gy, gs, cyc);
    check("R5", "all-tie seeded mv_x", gx, 7);
    check("R5", "all-tie seeded mv_y", gy, 7);
    run(3, -2, 1'b1, 0, gx, gy, gs, cyc);
    check("R6", "skip stage top-left mv_x", gx, -1);
    check("R6", "skip stage top-left mv_y", gy, -6);
  endtask

  task automatic t_cur_write();
    int gx, gy, gs, cyc;
    for (int r = 0; r < WIN; r++) for (int c = 0; c < WIN; c++) wbuf[r][c] = 8'd0;
    for (int r = 0; r < MB; r++) for (int c = 0; c < MB; c++) cbuf[r][c] = 8'd0;
    cbuf[3][5] = 8'd77;
    cbuf[14][15] = 8'd5;
    load_all();
    run(0, 0, 1'b0, 0, gx, gy, gs, cyc);
    check("R1", "single current pixels give sad", gs, 82);
  endtask

  task automatic t_exact_random();
    int gx, gy, gs, cyc;
    for (int r = 0; r < WIN; r++) for (int c = 0; c < WIN; c++) wbuf[r][c] = rnd8();
    cur_from_win(0, 0);
    load_all();
    run(0, 0, 1'b0, 0, gx, gy, gs, cyc);
    check("R3", "centre match mv_x", gx, 0);
    check("R3", "centre match mv_y", gy, 0);
    check("R2", "centre match sad", gs, 0);
    cur_from_win(5, -7);
    load_all();
    run(5, -7, 1'b1, 0, gx, gy, gs, cyc);
    check("R6", "seeded match mv_x", gx, 5);
    check("R6", "seeded match mv_y", gy, -7);
    check("R6", "seeded match sad", gs, 0);
    cur_from_win(16, -16);
    load_all();
    run(20, -20, 1'b1, 0, gx, gy, gs, cyc);
    check("R4", "clamped seed mv_x", gx, 16);
    check("R4", "clamped seed mv_y", gy, -16);
    check("R4", "clamped seed sad", gs, 0);
  endtask

  task automatic t_reference();
    for (int r = 0; r < WIN; r++) for (int c = 0; c < WIN; c++) wbuf[r][c] = rnd8();
    cur_from_win(7, 3);
    for (int r = 0; r < MB; r++) for (int c = 0; c < MB; c++)
      cbuf[r][c] = cbuf[r][c] ^ {5'd0, rnd8() % 8'd4, 1'b0};
    load_all();
    compare_ref("R3", 0, 0, 1'b0);
    compare_ref("R6", -6, 11, 1'b1);
    for (int r = 0; r < WIN; r++) for (int c = 0; c < WIN; c++)
      wbuf[r][c] = 8'((c * c) / 16 + r * 2);
    cur_from_win(-10, 6);
    load_all();
    compare_ref("R3", 0, 0, 1'b0);
    compare_ref("R4", 14, -15, 1'b0);
  endtask

  task automatic t_busy_start();
    int gx, gy, gs, cyc, rx, ry, rs;
    int extra = 0;
    ref_search(0, 0, 1'b0, rx, ry, rs);
    run(0, 0, 1'b0, 100, gx, gy, gs, cyc);
    check("R8", "start while busy: mv_x", gx, rx);
    check("R8", "start while busy: mv_y", gy, ry);
    check("R8", "start while busy: sad", gs, rs);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (done) extra++;
      if (busy) extra++;
    end
    check("R8", "no second search after ignored start", extra, 0);
    check("R8", "mv_x held after done", int'(mv_x), rx);
    check("R8", "best_sad held after done", int'(best_sad), rs);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tie_uniform();
    t_cur_write();
    t_exact_random();
    t_reference();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule